// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns one asynchronous serial input line into characters. An external rate generator supplies a sample-enable pulse, `OVS` pulses per bit time. The block confirms a start bit, then takes 7 or 8 data bits with the least significant bit first. An optional parity bit with even or odd sense follows, and then one or two stop bits. Each bit is sampled once near its middle. A finished character goes into a receive buffer and raises a ready flag. A read strobe takes the character away.

Four sticky status bits record receive problems: stop bit low (frame), parity mismatch, a character that arrives while the buffer is still full (overrun), and a line held low for longer than ten bit times (break). A summary bit shows that any of them is set. Software clears them together with a clear strobe. A mode input decides whether characters with a frame or parity error reach the buffer. The receive interrupt request is held off while a frame, parity or break flag is set. A software reset input holds the flags, the ready bit and the interrupt request at zero.

Top module: `uart_rx_core`

## Requirements
- R1: A frame is a low start bit, then 7 (`cfg_char8`=0) or 8 (`cfg_char8`=1) data bits with bit 0 first. In 7-bit mode `rx_data[7]` reads 0.
- R2: With `cfg_par_en`=1 a parity bit follows the last data bit. `cfg_par_even`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `err_parity`. With `cfg_par_en`=0 no parity bit is taken.
- R3: `cfg_two_stop`=0 takes one stop bit and 1 takes two. If any stop bit samples low, `err_frame` is set.
- R4: A low pulse that has ended by the middle of the start bit is not a start. No character results.
- R5: If a character goes to the buffer while `rx_ready` is 1 and no read happens in that cycle, `err_overrun` is set.
- R6: `err_break` is set once the line has been low for more than 10 bit times. A low span of exactly 10 bit times does not set it.
- R7: `err_any` is 1 whenever any of the four error flags is 1. The flags stay set until `err_clr` is pulsed.
- R8: With `cfg_err_ie`=0, a character with a frame or parity error does not reach the buffer and does not raise `rx_ready`. With `cfg_err_ie`=1, every character does.
- R9: `rx_irq` is `rx_ie` AND `rx_ready`, and it is forced to 0 while `err_frame`, `err_parity` or `err_break` is set. `err_overrun` alone does not block it.
- R10: While `sw_rst` is 1, `rx_ready`, all error flags and `rx_irq` are 0.
- R11: A pulse on `rx_rd` clears `rx_ready` on the next clock, unless a new character lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_rst | input | 1 | Software reset, holds flags and ready at 0 |
| smp_tick | input | 1 | Sample enable, OVS pulses per bit time |
| rx_line | input | 1 | Serial input, idle high |
| cfg_char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_err_ie | input | 1 | 1: errored characters also go to the buffer |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_rd | input | 1 | Buffer read strobe |
| err_clr | input | 1 | Clears the four error flags |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Buffer holds an unread character |
| err_frame | output | 1 | Sticky stop bit error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_break | output | 1 | Sticky break |
| err_any | output | 1 | OR of the four error flags |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach is the break condition next to its boundary. The line must stay low across the start bit, all data bits, the parity bit and into the stop bits, and the cut-off lies between ten and eleven bit times. The bench therefore sends an all-zero 8-bit frame with even parity and one stop bit, which keeps the line low for exactly ten bits. It then holds the line low for twelve bits with the error mode on. It checks that the second case gives a buffered frame error, a set break flag and a blocked interrupt. Random frames with injected parity and stop faults, and characters left unread, cover the filtering and overrun rules.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: data field never wider than 8 bits.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITH
    } rx_state_e;

    typedef struct packed {
        logic char8;
        logic par_en;
        logic par_even;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       fe;
        logic       pe;
    } rx_frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
// Module: input synchronizer for the serial line.
// Assumes: the line idles high, so reset loads ones.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= 1'b1;
                else        pipe <= d;
            end
        end else begin : g_many
            // Shift the line through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
// Module: start detection, mid-bit sampling and frame assembly.
// Assumes: OVS ticks per bit, OVS even and >= 4; the configuration is
// captured when a start edge is seen and is held for the whole frame.
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_rst,
    input  logic      tick,
    input  logic      line,
    input  rx_cfg_t   cfg,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

    rx_state_e   state;
    logic [CW-1:0] cnt;
    logic [2:0]  idx;
    logic        stop_n;
    logic [7:0]  shreg;
    logic        par_acc;
    logic        par_bad;
    logic        fe_acc;
    rx_cfg_t     cfg_q;
    logic        at_mid;
    logic [2:0]  last_idx;

    assign at_mid   = (cnt == CNT_LAST);
    assign last_idx = cfg_q.char8 ? 3'd7 : 3'd6;

    // Frame state machine, advanced on sample ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            stop_n  <= 1'b0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            fe_acc  <= 1'b0;
            cfg_q   <= '0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= '0;
                            cfg_q <= cfg;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_MID) begin
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_DATA;
                                cnt     <= '0;
                                idx     <= '0;
                                shreg   <= '0;
                                par_acc <= 1'b0;
                                par_bad <= 1'b0;
                                fe_acc  <= 1'b0;
                                stop_n  <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_mid) begin
                            cnt        <= '0;
                            shreg[idx] <= line;
                            par_acc    <= par_acc ^ line;
                            if (idx == last_idx) begin
                                idx   <= '0;
                                state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_mid) begin
                            cnt     <= '0;
                            par_bad <= par_acc ^ line ^ ~cfg_q.par_even;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_mid) begin
                            cnt <= '0;
                            if (cfg_q.two_stop && !stop_n) begin
                                stop_n <= 1'b1;
                                fe_acc <= fe_acc | ~line;
                            end else begin
                                done       <= 1'b1;
                                frame.data <= shreg;
                                frame.fe   <= fe_acc | ~line;
                                frame.pe   <= par_bad;
                                state      <= line ? ST_IDLE : ST_WAITH;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAITH: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_brk.sv
// Module: break detector, counts consecutive low samples.
// Assumes: LIMIT is the number of low ticks that marks a break.
module uart_rx_brk #(
    parameter int LIMIT = 161
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic tick,
    input  logic line,
    output logic hit
);
    localparam int BW = $clog2(LIMIT + 1);
    localparam logic [BW-1:0] CNT_TOP = BW'(LIMIT);
    localparam logic [BW-1:0] CNT_PRE = BW'(LIMIT - 1);

    logic [BW-1:0] low_cnt;

    // Saturating low-time counter and one-cycle hit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            low_cnt <= '0;
            hit     <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (tick) begin
                if (line) begin
                    low_cnt <= '0;
                end else if (low_cnt != CNT_TOP) begin
                    low_cnt <= low_cnt + 1'b1;
                    if (low_cnt == CNT_PRE) hit <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
// Module: receive buffer, ready flag, sticky error flags and interrupt.
// Assumes: done is a one-cycle pulse carrying the finished frame.
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_rst,
    input  logic      done,
    input  rx_frame_t frame,
    input  logic      brk_hit,
    input  logic      err_ie,
    input  logic      rx_ie,
    input  logic      rd,
    input  logic      clr,
    output logic [7:0] data,
    output logic      ready,
    output logic      fe,
    output logic      pe,
    output logic      oe,
    output logic      brk,
    output logic      any,
    output logic      irq
);
    logic bad_frame;
    logic wr;
    logic ie_eff;

    assign bad_frame = frame.fe | frame.pe;
    assign wr        = done & (~bad_frame | err_ie);
    assign ie_eff    = rx_ie & ~sw_rst;

    // Buffer load; contents survive software reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  data <= '0;
        else if (wr) data <= frame.data;
    end

    // Ready flag: set on a buffered character, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) ready <= 1'b0;
        else if (wr)          ready <= 1'b1;
        else if (rd)          ready <= 1'b0;
    end

    // Sticky error flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            fe  <= 1'b0;
            pe  <= 1'b0;
            oe  <= 1'b0;
            brk <= 1'b0;
        end else begin
            if (done && frame.fe) fe <= 1'b1;
            else if (clr)         fe <= 1'b0;
            if (done && frame.pe) pe <= 1'b1;
            else if (clr)         pe <= 1'b0;
            if (wr && ready && !rd) oe <= 1'b1;
            else if (clr)           oe <= 1'b0;
            if (brk_hit)          brk <= 1'b1;
            else if (clr)         brk <= 1'b0;
        end
    end

    assign any = fe | pe | oe | brk;
    assign irq = ie_eff & ready & ~(fe | pe | brk);
endmodule

// File: rtl/uart_rx_core.sv
// Module: top of the serial receiver.
// Assumes: smp_tick gives OVS pulses per bit time from an external
// rate generator; the configuration is stable while a frame arrives.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SYNC_STG  = 2,
    parameter int BRK_BITS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       smp_tick,
    input  logic       rx_line,
    input  logic       cfg_char8,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_two_stop,
    input  logic       cfg_err_ie,
    input  logic       rx_ie,
    input  logic       rx_rd,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       err_break,
    output logic       err_any,
    output logic       rx_irq
);
    localparam int BRK_LIMIT = BRK_BITS * OVS + 1;

    logic      line_s;
    rx_cfg_t   cfg;
    rx_frame_t frm;
    logic      frm_done;
    logic      frm_fe;
    logic      frm_pe;
    logic      brk_hit;

    assign cfg.char8    = cfg_char8;
    assign cfg.par_en   = cfg_par_en;
    assign cfg.par_even = cfg_par_even;
    assign cfg.two_stop = cfg_two_stop;
    assign frm_fe       = frm.fe;
    assign frm_pe       = frm.pe;

    uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (line_s)
    );

    uart_rx_sampler #(.OVS(OVS)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .tick   (smp_tick),
        .line   (line_s),
        .cfg    (cfg),
        .done   (frm_done),
        .frame  (frm)
    );

    uart_rx_brk #(.LIMIT(BRK_LIMIT)) u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .tick   (smp_tick),
        .line   (line_s),
        .hit    (brk_hit)
    );

    uart_rx_status u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .done    (frm_done),
        .frame   (frm),
        .brk_hit (brk_hit),
        .err_ie  (cfg_err_ie),
        .rx_ie   (rx_ie),
        .rd      (rx_rd),
        .clr     (err_clr),
        .data    (rx_data),
        .ready   (rx_ready),
        .fe      (err_frame),
        .pe      (err_parity),
        .oe      (err_overrun),
        .brk     (err_break),
        .any     (err_any),
        .irq     (rx_irq)
    );
endmodule

// File: rtl/uart_rx_chk.sv
// Module: property checker for the serial receiver, bound to the top.
module uart_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_rst,
    input logic rx_rd,
    input logic err_clr,
    input logic cfg_err_ie,
    input logic rx_ready,
    input logic err_frame,
    input logic err_parity,
    input logic err_overrun,
    input logic err_break,
    input logic rx_irq,
    input logic frm_done,
    input logic frm_fe,
    input logic frm_pe
);
    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame || err_parity || err_break) |-> !rx_irq); // R9

    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!rx_ready && !err_frame && !err_parity && !err_overrun && !err_break)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr && !sw_rst) |=> err_parity); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !frm_done && !sw_rst) |=> !rx_ready); // R11

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_fe && !frm_pe && rx_ready && !rx_rd && !sw_rst) |=> err_overrun); // R5

    AST_ERR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && (frm_fe || frm_pe) && !cfg_err_ie && !rx_ready && !sw_rst) |=> !rx_ready); // R8

    AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_fe && !sw_rst) |=> err_frame); // R3
endmodule

bind uart_rx_core uart_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .rx_rd       (rx_rd),
    .err_clr     (err_clr),
    .cfg_err_ie  (cfg_err_ie),
    .rx_ready    (rx_ready),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .err_break   (err_break),
    .rx_irq      (rx_irq),
    .frm_done    (frm_done),
    .frm_fe      (frm_fe),
    .frm_pe      (frm_pe)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
    localparam int OVS    = 16;
    localparam int BITCYC = OVS * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_rst = 1'b0;
    logic smp_tick = 1'b0;
    logic rx_line = 1'b1;
    logic cfg_char8 = 1'b1, cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
    logic cfg_err_ie = 1'b0, rx_ie = 1'b1, rx_rd = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic rx_ready, err_frame, err_parity, err_overrun, err_break, err_any, rx_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done_run = 0;

    // model state
    logic [7:0] m_data = 8'h00;
    bit m_ready = 0, m_fe = 0, m_pe = 0, m_oe = 0, m_brk = 0;

    uart_rx_core #(.OVS(OVS)) dut (.*);

    always #2.5 clk = ~clk;

    // sample enable every second cycle
    always @(negedge clk) begin
        if (!rst_n) smp_tick <= 1'b0;
        else        smp_tick <= ~smp_tick;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        rx_line = b;
        wait_cyc(BITCYC);
    endtask

    function automatic logic par_of(input logic [7:0] d, input bit c8, input bit even);
        logic p;
        p = c8 ? ^d : ^d[6:0];
        return even ? p : ~p;
    endfunction

    // send one frame, optional parity fault and first-stop fault
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int nb;
        nb = cfg_char8 ? 8 : 7;
        put_bit(1'b0);
        for (int i = 0; i < nb; i++) put_bit(d[i]);
        if (cfg_par_en) put_bit(par_of(d, cfg_char8, cfg_par_even) ^ bad_par);
        put_bit(~bad_stop);
        if (cfg_two_stop) put_bit(1'b1);
        put_bit(1'b1);
    endtask

    // model update for a completed frame
    task automatic model_frame(input logic [7:0] d, input bit fe, input bit pe);
        bit wr;
        wr = !(fe || pe) || cfg_err_ie;
        if (fe) m_fe = 1;
        if (pe) m_pe = 1;
        if (wr) begin
            if (m_ready) m_oe = 1;
            m_ready = 1;
            m_data = cfg_char8 ? d : {1'b0, d[6:0]};
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R11 ready"}, rx_ready, m_ready);
        if (m_ready) chk({tag, " R1 data"}, rx_data, m_data);
        chk({tag, " R3 frame"}, err_frame, m_fe);
        chk({tag, " R2 parity"}, err_parity, m_pe);
        chk({tag, " R5 overrun"}, err_overrun, m_oe);
        chk({tag, " R6 break"}, err_break, m_brk);
        chk({tag, " R7 any"}, err_any, m_fe | m_pe | m_oe | m_brk);
        chk({tag, " R9 irq"}, rx_irq, rx_ie & m_ready & !(m_fe | m_pe | m_brk));
    endtask

    task automatic do_read();
        rx_rd = 1'b1; wait_cyc(1); rx_rd = 1'b0; wait_cyc(1);
        m_ready = 0;
    endtask

    task automatic do_clear();
        err_clr = 1'b1; wait_cyc(1); err_clr = 1'b0; wait_cyc(1);
        m_fe = 0; m_pe = 0; m_oe = 0; m_brk = 0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed1);
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(4);
        check_all("reset R10");

        // R1/R2/R3 directed: 8E2 frame, value with bits 0 and 7 set
        cfg_char8 = 1; cfg_par_en = 1; cfg_par_even = 1; cfg_two_stop = 1;
        send_frame(8'h81, 0, 0); model_frame(8'h81, 0, 0);
        check_all("dir 8E2");
        do_read();
        chk("R11 read clears ready", rx_ready, 1'b0);

        // R4 glitch shorter than half a bit
        rx_line = 1'b0; wait_cyc(8); rx_line = 1'b1; wait_cyc(3 * BITCYC);
        chk("R4 glitch no ready", rx_ready, 1'b0);
        chk("R4 glitch no frame error", err_frame, 1'b0);

        // R6 boundary: exactly ten low bit times, 8 data even parity one stop
        cfg_two_stop = 0;
        send_frame(8'h00, 0, 0); model_frame(8'h00, 0, 0);
        check_all("R6 ten bits low");
        do_read();

        // R6 break: twelve bit times low, errored char kept (R8)
        cfg_par_en = 0; cfg_err_ie = 1;
        rx_line = 1'b0; wait_cyc(12 * BITCYC); rx_line = 1'b1; wait_cyc(2 * BITCYC);
        model_frame(8'h00, 1, 0); m_brk = 1;
        check_all("R6 break");
        chk("R9 irq blocked by break", rx_irq, 1'b0);

        // R10 software reset while flags set
        sw_rst = 1'b1; wait_cyc(2);
        chk("R10 ready held", rx_ready, 1'b0);
        chk("R10 any held", err_any, 1'b0);
        chk("R10 irq held", rx_irq, 1'b0);
        sw_rst = 1'b0; wait_cyc(2);
        m_ready = 0; m_fe = 0; m_pe = 0; m_oe = 0; m_brk = 0;
        check_all("after R10");

        // R8 filter: parity error with err_ie=0 is dropped
        cfg_err_ie = 0; cfg_par_en = 1; cfg_par_even = 0;
        send_frame(8'h5A, 1, 0); model_frame(8'h5A, 0, 1);
        check_all("R8 filtered");
        chk("R8 filtered ready", rx_ready, 1'b0);
        do_clear();

        // R5/R9 overrun alone does not block irq
        send_frame(8'h11, 0, 0); model_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0); model_frame(8'h22, 0, 0);
        check_all("R5 overrun");
        chk("R9 irq with overrun only", rx_irq, 1'b1);
        do_read(); do_clear();
        check_all("R7 cleared");

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            bit bp, bs, keep;
            d            = 8'($urandom);
            cfg_char8    = $urandom % 2;
            cfg_par_en   = $urandom % 2;
            cfg_par_even = $urandom % 2;
            cfg_two_stop = $urandom % 2;
            cfg_err_ie   = $urandom % 2;
            rx_ie        = ($urandom % 4) != 0;
            bp   = cfg_par_en && (($urandom % 4) == 0);
            bs   = ($urandom % 5) == 0;
            keep = ($urandom % 4) == 0;
            wait_cyc(2);
            send_frame(d, bp, bs);
            model_frame(d, bs, bp);
            check_all("rand");
            if (!keep) do_read();
            if (($urandom % 2) == 0) do_clear();
        end

        finish_run();
    end
endmodule